// File: doc/BRIEF.md
# USB Endpoint Interrupt Flag Aggregator

This block gathers the event pulses raised by the controllers of USB endpoints 1 to 5 and turns them into sticky per-endpoint flags. Each endpoint has one IN flag and one OUT flag. An IN flag records a completed transmission, a handshake refusal (STALL) sent, or a flushed transmit buffer. An OUT flag records a received packet or a STALL sent. Bit i of every endpoint-indexed vector belongs to endpoint i+1.

A flag is recorded whatever its mask bit says. The mask has two jobs. It decides whether an event also sets the CPU-level USB pending flag. It also decides whether a recorded flag takes part in the interrupt request. The request also needs the global USB interrupt enable. Firmware clears endpoint flags and the pending flag with one-cycle write pulses. A set that arrives in the same cycle as a clear always wins.

Top module: `usb_ep_irq_agg`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all IN and OUT flags, `cpu_pend` and `irq_req` are 0.
- R2: A pulse on any of `in_pkt_sent`, `in_stall_sent` or `in_flush` for endpoint bit i sets `in_flags[i]` one clock later, whatever the value of `in_mask[i]`.
- R3: A pulse on either `out_pkt_rcvd` or `out_stall_sent` for endpoint bit i sets `out_flags[i]` one clock later, whatever the value of `out_mask[i]`.
- R4: A set flag stays 1 until a pulse on its own clear bit (`in_flag_clr[i]` or `out_flag_clr[i]`). It then reads 0 one clock later, and no other flag changes.
- R5: If a flag's set event and its clear pulse arrive in the same cycle, the flag reads 1 one clock later.
- R6: `cpu_pend` becomes 1 one clock after an event on an endpoint whose mask bit for that direction is 1. An event on an endpoint whose mask bit is 0 does not change `cpu_pend`.
- R7: `cpu_pend` stays 1 until a `cpu_pend_clr` pulse, which clears it one clock later. A qualifying event in the same cycle as the clear keeps it at 1.
- R8: `irq_req` equals `usb_irq_en` AND the OR, over all endpoints and both directions, of (flag AND mask). It follows mask and enable changes in the same cycle, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_pkt_sent | input | 5 | Per-endpoint pulse: IN packet delivered to host |
| in_stall_sent | input | 5 | Per-endpoint pulse: STALL sent on IN endpoint |
| in_flush | input | 5 | Per-endpoint pulse: IN buffer flushed |
| out_pkt_rcvd | input | 5 | Per-endpoint pulse: OUT packet received |
| out_stall_sent | input | 5 | Per-endpoint pulse: STALL sent on OUT endpoint |
| in_mask | input | 5 | Per-endpoint IN mask (1 = enabled) |
| out_mask | input | 5 | Per-endpoint OUT mask (1 = enabled) |
| usb_irq_en | input | 1 | Global USB interrupt enable |
| in_flag_clr | input | 5 | Write-one pulse clearing IN flags |
| out_flag_clr | input | 5 | Write-one pulse clearing OUT flags |
| cpu_pend_clr | input | 1 | Pulse clearing the CPU pending flag |
| in_flags | output | 5 | Sticky IN event flags |
| out_flags | output | 5 | Sticky OUT event flags |
| cpu_pend | output | 1 | CPU-level USB pending flag |
| irq_req | output | 1 | Interrupt request line |

## Verification
All internal state is in the ten flag bits and the pending bit. The flag bits are outputs, so any wrong flag state shows on `in_flags` or `out_flags` one clock after the event or clear that caused it. A pending bit set from a masked endpoint, or lost on a same-cycle clear, shows on `cpu_pend` the next cycle. A wrong gating term shows on `irq_req` in the same cycle as the mask or enable change that exposes it. Every cycle the bench compares all four outputs against a model kept in the bench, so a divergence is reported no later than one cycle after it arises.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    // Number of interrupt-capable endpoints (numbered 1..EP_COUNT).
    parameter int EP_COUNT = 5;
    // Event sources feeding each direction.
    parameter int IN_SRC_COUNT  = 3;
    parameter int OUT_SRC_COUNT = 2;
endpackage

// File: rtl/ep_event_merge.sv
// Reduces several per-endpoint event sources into one set pulse per endpoint.
module ep_event_merge #(
    parameter int N_EP  = usb_irq_pkg::EP_COUNT,
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0][N_EP-1:0] src_ev,
    output logic [N_EP-1:0]            ep_ev
);
    genvar e;
    generate
        for (e = 0; e < N_EP; e++) begin : g_ep
            logic [N_SRC-1:0] col;
            always_comb begin
                for (int s = 0; s < N_SRC; s++) col[s] = src_ev[s][e];
            end
            assign ep_ev[e] = |col;
        end
    endgenerate
endmodule

// File: rtl/ep_flag_bank.sv
// Sticky flag register: set has priority over clear.
module ep_flag_bank #(
    parameter int N_EP = usb_irq_pkg::EP_COUNT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EP-1:0] set_vec,
    input  logic [N_EP-1:0] clr_vec,
    output logic [N_EP-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_vec) | set_vec;
    end

    // R2/R3/R5: a set event is visible next cycle regardless of clear
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    // R4: flags without clear keep their value
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flags) & ~$past(clr_vec)) & ~flags) == '0));

    // R4: a cleared flag with no set reads 0
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((flags & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/irq_gate.sv
// CPU pending flag and the gated request line.
module irq_gate #(
    parameter int N_EP = usb_irq_pkg::EP_COUNT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EP-1:0] in_ev,
    input  logic [N_EP-1:0] out_ev,
    input  logic [N_EP-1:0] in_mask,
    input  logic [N_EP-1:0] out_mask,
    input  logic [N_EP-1:0] in_flags,
    input  logic [N_EP-1:0] out_flags,
    input  logic            usb_irq_en,
    input  logic            pend_clr,
    output logic            pend,
    output logic            req
);
    logic ev_hit;
    logic flag_hit;

    assign ev_hit   = |((in_ev & in_mask) | (out_ev & out_mask));
    assign flag_hit = |((in_flags & in_mask) | (out_flags & out_mask));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend & ~pend_clr) | ev_hit;
    end

    assign req = usb_irq_en & flag_hit;

    // R6: pending only rises after an unmasked event
    assert_pend_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(|((in_ev & in_mask) | (out_ev & out_mask))));

    // R7: pending holds without a clear
    assert_pend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !pend_clr) |=> pend);

    // R8: request only with global enable
    assert_req_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> usb_irq_en);

    // R8: request needs a flag that is also unmasked
    assert_req_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ((in_flags & in_mask) != '0 || (out_flags & out_mask) != '0));
endmodule

// File: rtl/usb_ep_irq_agg.sv
module usb_ep_irq_agg #(
    parameter int N_EP = usb_irq_pkg::EP_COUNT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EP-1:0] in_pkt_sent,
    input  logic [N_EP-1:0] in_stall_sent,
    input  logic [N_EP-1:0] in_flush,
    input  logic [N_EP-1:0] out_pkt_rcvd,
    input  logic [N_EP-1:0] out_stall_sent,
    input  logic [N_EP-1:0] in_mask,
    input  logic [N_EP-1:0] out_mask,
    input  logic            usb_irq_en,
    input  logic [N_EP-1:0] in_flag_clr,
    input  logic [N_EP-1:0] out_flag_clr,
    input  logic            cpu_pend_clr,
    output logic [N_EP-1:0] in_flags,
    output logic [N_EP-1:0] out_flags,
    output logic            cpu_pend,
    output logic            irq_req
);
    import usb_irq_pkg::*;

    localparam int IN_N  = IN_SRC_COUNT;
    localparam int OUT_N = OUT_SRC_COUNT;

    logic [IN_N-1:0][N_EP-1:0]  in_src;
    logic [OUT_N-1:0][N_EP-1:0] out_src;
    logic [N_EP-1:0]            in_ev;
    logic [N_EP-1:0]            out_ev;

    assign in_src  = {in_flush, in_stall_sent, in_pkt_sent};
    assign out_src = {out_stall_sent, out_pkt_rcvd};

    ep_event_merge #(.N_EP(N_EP), .N_SRC(IN_N)) u_in_merge (
        .src_ev (in_src),
        .ep_ev  (in_ev)
    );

    ep_event_merge #(.N_EP(N_EP), .N_SRC(OUT_N)) u_out_merge (
        .src_ev (out_src),
        .ep_ev  (out_ev)
    );

    ep_flag_bank #(.N_EP(N_EP)) u_in_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (in_ev),
        .clr_vec (in_flag_clr),
        .flags   (in_flags)
    );

    ep_flag_bank #(.N_EP(N_EP)) u_out_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (out_ev),
        .clr_vec (out_flag_clr),
        .flags   (out_flags)
    );

    irq_gate #(.N_EP(N_EP)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_ev      (in_ev),
        .out_ev     (out_ev),
        .in_mask    (in_mask),
        .out_mask   (out_mask),
        .in_flags   (in_flags),
        .out_flags  (out_flags),
        .usb_irq_en (usb_irq_en),
        .pend_clr   (cpu_pend_clr),
        .pend       (cpu_pend),
        .req        (irq_req)
    );

    // R2: an IN source event is recorded even when masked
    assert_in_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_pkt_sent | in_stall_sent | in_flush) != '0)
        |=> ((in_flags & $past(in_pkt_sent | in_stall_sent | in_flush))
             == $past(in_pkt_sent | in_stall_sent | in_flush)));

    // R3: an OUT source event is recorded even when masked
    assert_out_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_pkt_rcvd | out_stall_sent) != '0)
        |=> ((out_flags & $past(out_pkt_rcvd | out_stall_sent))
             == $past(out_pkt_rcvd | out_stall_sent)));
endmodule

// File: tb/usb_ep_irq_agg_tb.sv
module usb_ep_irq_agg_tb;
    localparam int N = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] in_pkt_sent = '0, in_stall_sent = '0, in_flush = '0;
    logic [N-1:0] out_pkt_rcvd = '0, out_stall_sent = '0;
    logic [N-1:0] in_mask = '0, out_mask = '0;
    logic         usb_irq_en = 1'b0;
    logic [N-1:0] in_flag_clr = '0, out_flag_clr = '0;
    logic         cpu_pend_clr = 1'b0;
    logic [N-1:0] in_flags, out_flags;
    logic         cpu_pend, irq_req;

    int checks = 0;
    int failures = 0;
    logic [N-1:0] exp_in = '0, exp_out = '0;
    logic         exp_pend = 1'b0;

    always #4 clk = ~clk;

    usb_ep_irq_agg u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_pkt_sent(in_pkt_sent), .in_stall_sent(in_stall_sent), .in_flush(in_flush),
        .out_pkt_rcvd(out_pkt_rcvd), .out_stall_sent(out_stall_sent),
        .in_mask(in_mask), .out_mask(out_mask), .usb_irq_en(usb_irq_en),
        .in_flag_clr(in_flag_clr), .out_flag_clr(out_flag_clr), .cpu_pend_clr(cpu_pend_clr),
        .in_flags(in_flags), .out_flags(out_flags), .cpu_pend(cpu_pend), .irq_req(irq_req)
    );

    function automatic logic model_req(logic [N-1:0] fi, logic [N-1:0] fo,
                                       logic [N-1:0] mi, logic [N-1:0] mo, logic en);
        return en & (|((fi & mi) | (fo & mo)));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " in_flags"},  32'(in_flags),  32'(exp_in));
        chk({tag, " out_flags"}, 32'(out_flags), 32'(exp_out));
        chk({tag, " cpu_pend"},  32'(cpu_pend),  32'(exp_pend));
        chk({tag, " irq_req R8"}, 32'(irq_req),
            32'(model_req(exp_in, exp_out, in_mask, out_mask, usb_irq_en)));
    endtask

    // Apply the current stimulus for one clock, update the model, check.
    task automatic step(string tag);
        logic [N-1:0] ei, eo;
        @(posedge clk);
        ei = in_pkt_sent | in_stall_sent | in_flush;
        eo = out_pkt_rcvd | out_stall_sent;
        exp_pend = (exp_pend & ~cpu_pend_clr) | (|((ei & in_mask) | (eo & out_mask)));
        exp_in   = (exp_in & ~in_flag_clr) | ei;
        exp_out  = (exp_out & ~out_flag_clr) | eo;
        @(negedge clk);
        #1;
        in_pkt_sent = '0; in_stall_sent = '0; in_flush = '0;
        out_pkt_rcvd = '0; out_stall_sent = '0;
        in_flag_clr = '0; out_flag_clr = '0; cpu_pend_clr = 1'b0;
        check_all(tag);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R1: reset state
        repeat (2) @(negedge clk);
        #1;
        in_mask = '1; out_mask = '1; usb_irq_en = 1'b1;
        #1;
        check_all("R1 in reset");
        rst_n = 1'b1;
        step("R1 after reset");

        // R2 + R6: masked IN stall on endpoint 3 latches flag, no pending
        in_mask = 5'b11011; out_mask = '0;
        in_stall_sent = 5'b00100;
        step("R2 R6 masked IN event");
        chk("R2 flag bit", 32'(in_flags[2]), 32'd1);
        chk("R6 masked no pend", 32'(cpu_pend), 32'd0);
        chk("R8 masked flag no req", 32'(irq_req), 32'd0);

        // R8: unmask afterwards raises request combinationally
        in_mask = 5'b11111;
        #1;
        chk("R8 unmask raises req", 32'(irq_req), 32'd1);
        usb_irq_en = 1'b0;
        #1;
        chk("R8 global enable gates req", 32'(irq_req), 32'd0);
        usb_irq_en = 1'b1;

        // R3 + R6: OUT packet on unmasked endpoint 5 sets pending
        out_mask = 5'b10000;
        out_pkt_rcvd = 5'b10000;
        step("R3 R6 unmasked OUT event");
        chk("R6 pend set", 32'(cpu_pend), 32'd1);

        // R4: clear endpoint 3 IN flag, others stay
        in_flush = 5'b00001;
        step("R2 flush ep1");
        in_flag_clr = 5'b00100;
        step("R4 clear single flag");
        chk("R4 cleared", 32'(in_flags), 32'b00001);

        // R5: set and clear together on endpoint 2 OUT
        out_stall_sent = 5'b00010; out_flag_clr = 5'b00010;
        step("R5 set beats clear");
        chk("R5 flag kept", 32'(out_flags[1]), 32'd1);

        // R7: pend clear with simultaneous qualifying event keeps pend
        cpu_pend_clr = 1'b1; in_pkt_sent = 5'b01000;
        step("R7 set beats pend clear");
        chk("R7 pend kept", 32'(cpu_pend), 32'd1);
        cpu_pend_clr = 1'b1;
        step("R7 pend clear");
        chk("R7 pend cleared", 32'(cpu_pend), 32'd0);

        // Random phase over all requirements (R2..R8)
        for (int i = 0; i < 400; i++) begin
            in_pkt_sent    = 5'($urandom) & 5'($urandom) & 5'($urandom);
            in_stall_sent  = 5'($urandom) & 5'($urandom) & 5'($urandom);
            in_flush       = 5'($urandom) & 5'($urandom) & 5'($urandom);
            out_pkt_rcvd   = 5'($urandom) & 5'($urandom) & 5'($urandom);
            out_stall_sent = 5'($urandom) & 5'($urandom) & 5'($urandom);
            in_flag_clr    = 5'($urandom) & 5'($urandom);
            out_flag_clr   = 5'($urandom) & 5'($urandom);
            cpu_pend_clr   = ($urandom % 4) == 0;
            if ((i % 8) == 0) begin
                in_mask    = 5'($urandom);
                out_mask   = 5'($urandom);
                usb_irq_en = ($urandom % 4) != 0;
            end
            step("R2 R3 R4 R5 R6 R7 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule